// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block sits behind the write port of a parallel NOR flash model or controller. It watches host write strobes and recognises the multi-cycle unlock patterns that guard every data-altering operation. Each strobe carries an address and a data word. Only the low 15 address bits and the low data byte take part in matching. When a pattern completes, the block raises a command pulse for one clock. The pulse carries a one-hot opcode, the target address and the write data. The array engine downstream acts on that pulse.

The decoder also holds the current read mode: normal array, identification or query table. While identification mode is active it supplies the two identification words on a small read port. A busy input from the array engine freezes the decoder. No write is accepted while busy is high, so a program or erase in flight cannot be disturbed. A write that breaks a pattern throws the decoder back to idle and selects array read mode.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, and after a reset applied in the middle of a pattern, readMode is 0 (array) and cmdValid is 0. A write that would have continued the interrupted pattern is then treated as a fresh first cycle.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by any fourth write, produce a program command. That command is opcode bit 0, with cmdAddr equal to the full fourth-write address and cmdData equal to the full 16-bit fourth-write data.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by a sixth write, produce an erase command. The sixth write selects it:
  - 10h@5555h gives chip erase: opcode bit 3, cmdAddr 0.
  - 30h at any address gives sector erase: opcode bit 1, cmdAddr with bits 10..0 cleared.
  - 50h at any address gives block erase: opcode bit 2, cmdAddr with bits 14..0 cleared.
- R4: After AAh@5555h and 55h@2AAAh, a third write at 5555h selects a mode command, each with its own pulse:
  - 90h enters identification mode: opcode bit 4, readMode 1.
  - 98h enters query mode: opcode bit 5, readMode 2.
  - F0h exits to array mode: opcode bit 6, readMode 0.
  - readMode never takes the value 3.
- R5: From idle, two single writes act on their own. 98h at address 0055h enters query mode (opcode bit 5, readMode 2). F0h at any address exits to array mode (opcode bit 6, readMode 0).
- R6: A write that does not match the expected cycle aborts. There is no pulse, the decoder returns to idle and readMode becomes 0. This covers a wrong cycle inside a pattern and an unrecognised write from idle. The next pattern must start again from its first cycle.
- R7: Address bits above bit 14 and data bits 15..8 never affect matching.
- R8: While busy is high, writes are ignored. No pulse is produced, readMode is unchanged, and a pattern in progress resumes where it stood once busy falls.
- R9: The ID read port gives idWord as follows:
  - In identification mode, rdAddr 0 returns 00BFh and rdAddr 1 returns the device ID (default 273Eh).
  - Any other address, or any other mode, returns 0000h.
- R10: cmdValid is high for exactly the one cycle after the completing write. cmdOp then has exactly one bit set, and cmdOp is zero whenever cmdValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Host write strobe, one cycle per bus write |
| wrAddr | input | ADDR_W (19) | Word address of the write |
| wrData | input | DATA_W (16) | Data of the write |
| busy | input | 1 | Array operation in progress; writes ignored |
| rdAddr | input | ADDR_W (19) | Word address for identification reads |
| cmdValid | output | 1 | One-cycle command pulse |
| cmdOp | output | 7 | One-hot opcode: 0 program, 1 sector, 2 block, 3 chip erase, 4 ID entry, 5 query entry, 6 exit |
| cmdAddr | output | ADDR_W (19) | Command target address |
| cmdData | output | DATA_W (16) | Program data, zero for other commands |
| readMode | output | 2 | 0 array, 1 identification, 2 query |
| idWord | output | DATA_W (16) | Identification word for rdAddr |

## Verification
The assertions assume that every host write lasts exactly one wrValid cycle. They also assume that busy is a level that only the array engine drives, so any write seen with busy high must leave no trace one cycle later. The stimulus raises wrValid for a single clock per write. It sets busy only together with chosen writes and drops it with them. It never holds reset across a sampled edge except in the dedicated mid-pattern reset test.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  localparam int OP_W = 7;
  localparam int KEY_AW = 15;

  localparam int OP_PROG   = 0;
  localparam int OP_SECTOR = 1;
  localparam int OP_BLOCK  = 2;
  localparam int OP_CHIP   = 3;
  localparam int OP_IDENT  = 4;
  localparam int OP_QUERY  = 5;
  localparam int OP_EXIT   = 6;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_IDENT = 2'd1,
    MODE_QUERY = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ADDR_ZERO   = 2'd0,
    ADDR_FULL   = 2'd1,
    ADDR_SECTOR = 2'd2,
    ADDR_BLOCK  = 2'd3
  } addr_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ER3, ST_ER4, ST_ER5
  } state_e;

  typedef struct packed {
    logic            load;
    logic [OP_W-1:0] op;
    addr_sel_e       addrSel;
    logic            keepData;
    logic            setMode;
    mode_e           newMode;
  } ctrl_t;

endpackage

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import unlock_pkg::*;
#(
  parameter logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA,
  parameter logic [KEY_AW-1:0] SHORT_ADDR = 15'h0055
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              busy,
  input  logic [KEY_AW-1:0] keyAddr,
  input  logic [7:0]        keyData,
  output ctrl_t             strobe
);

  state_e state, stateNxt;

  logic atA, atB;
  assign atA = (keyAddr == KEY_ADDR_A);
  assign atB = (keyAddr == KEY_ADDR_B);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    if (wrValid && !busy) begin
      // default outcome of any accepted write: abort to idle, array mode
      stateNxt       = ST_IDLE;
      strobe.setMode = 1'b1;
      strobe.newMode = MODE_ARRAY;
      unique case (state)
        ST_IDLE: begin
          if (atA && keyData == 8'hAA) begin
            stateNxt       = ST_KEY1;
            strobe.setMode = 1'b0;
          end else if (keyData == 8'hF0) begin
            strobe.load          = 1'b1;
            strobe.op[OP_EXIT]   = 1'b1;
          end else if (keyAddr == SHORT_ADDR && keyData == 8'h98) begin
            strobe.load          = 1'b1;
            strobe.op[OP_QUERY]  = 1'b1;
            strobe.newMode       = MODE_QUERY;
          end
        end
        ST_KEY1: begin
          if (atB && keyData == 8'h55) begin
            stateNxt       = ST_KEY2;
            strobe.setMode = 1'b0;
          end
        end
        ST_KEY2: begin
          if (atA) begin
            unique case (keyData)
              8'hA0: begin stateNxt = ST_PROG; strobe.setMode = 1'b0; end
              8'h80: begin stateNxt = ST_ER3;  strobe.setMode = 1'b0; end
              8'h90: begin
                strobe.load         = 1'b1;
                strobe.op[OP_IDENT] = 1'b1;
                strobe.newMode      = MODE_IDENT;
              end
              8'h98: begin
                strobe.load         = 1'b1;
                strobe.op[OP_QUERY] = 1'b1;
                strobe.newMode      = MODE_QUERY;
              end
              8'hF0: begin
                strobe.load        = 1'b1;
                strobe.op[OP_EXIT] = 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_PROG: begin
          strobe.setMode     = 1'b0;
          strobe.load        = 1'b1;
          strobe.op[OP_PROG] = 1'b1;
          strobe.addrSel     = ADDR_FULL;
          strobe.keepData    = 1'b1;
        end
        ST_ER3: begin
          if (atA && keyData == 8'hAA) begin
            stateNxt       = ST_ER4;
            strobe.setMode = 1'b0;
          end
        end
        ST_ER4: begin
          if (atB && keyData == 8'h55) begin
            stateNxt       = ST_ER5;
            strobe.setMode = 1'b0;
          end
        end
        ST_ER5: begin
          if (atA && keyData == 8'h10) begin
            strobe.setMode     = 1'b0;
            strobe.load        = 1'b1;
            strobe.op[OP_CHIP] = 1'b1;
          end else if (keyData == 8'h30) begin
            strobe.setMode       = 1'b0;
            strobe.load          = 1'b1;
            strobe.op[OP_SECTOR] = 1'b1;
            strobe.addrSel       = ADDR_SECTOR;
          end else if (keyData == 8'h50) begin
            strobe.setMode      = 1'b0;
            strobe.load         = 1'b1;
            strobe.op[OP_BLOCK] = 1'b1;
            strobe.addrSel      = ADDR_BLOCK;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/unlock_dp.sv
module unlock_dp
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int SECTOR_LSB = 11,
  parameter int BLOCK_LSB = 15,
  parameter logic [DATA_W-1:0] MANUF_ID = 16'h00BF,
  parameter logic [DATA_W-1:0] DEVICE_ID = 16'h273E
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              cmdValid,
  output logic [OP_W-1:0]   cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic [1:0]        readMode,
  output logic [DATA_W-1:0] idWord
);

  localparam logic [ADDR_W-1:0] SECTOR_MASK = {ADDR_W{1'b1}} << SECTOR_LSB;
  localparam logic [ADDR_W-1:0] BLOCK_MASK  = {ADDR_W{1'b1}} << BLOCK_LSB;

  logic [ADDR_W-1:0] addrPick;
  mode_e             modeQ;

  always_comb begin
    unique case (strobe.addrSel)
      ADDR_FULL:   addrPick = wrAddr;
      ADDR_SECTOR: addrPick = wrAddr & SECTOR_MASK;
      ADDR_BLOCK:  addrPick = wrAddr & BLOCK_MASK;
      default:     addrPick = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdOp    <= '0;
      cmdAddr  <= '0;
      cmdData  <= '0;
      modeQ    <= MODE_ARRAY;
    end else begin
      cmdValid <= strobe.load;
      cmdOp    <= strobe.load ? strobe.op : '0;
      if (strobe.load) begin
        cmdAddr <= addrPick;
        cmdData <= strobe.keepData ? wrData : '0;
      end
      if (strobe.setMode) modeQ <= strobe.newMode;
    end
  end

  assign readMode = modeQ;

  always_comb begin
    idWord = '0;
    if (modeQ == MODE_IDENT) begin
      if (rdAddr == ADDR_W'(0))      idWord = MANUF_ID;
      else if (rdAddr == ADDR_W'(1)) idWord = DEVICE_ID;
    end
  end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int SECTOR_LSB = 11,
  parameter int BLOCK_LSB = 15,
  parameter logic [DATA_W-1:0] MANUF_ID = 16'h00BF,
  parameter logic [DATA_W-1:0] DEVICE_ID = 16'h273E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              cmdValid,
  output logic [6:0]        cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic [1:0]        readMode,
  output logic [DATA_W-1:0] idWord
);

  ctrl_t strobe;

  unlock_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrValid (wrValid),
    .busy    (busy),
    .keyAddr (wrAddr[KEY_AW-1:0]),
    .keyData (wrData[7:0]),
    .strobe  (strobe)
  );

  unlock_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SECTOR_LSB (SECTOR_LSB),
    .BLOCK_LSB  (BLOCK_LSB),
    .MANUF_ID   (MANUF_ID),
    .DEVICE_ID  (DEVICE_ID)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .readMode (readMode),
    .idWord   (idWord)
  );

endmodule

// File: rtl/unlock_cmd_decoder_chk.sv
module unlock_cmd_decoder_chk #(
  parameter int ADDR_W = 19,
  parameter int SECTOR_LSB = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              busy,
  input logic              cmdValid,
  input logic [6:0]        cmdOp,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [1:0]        readMode
);

  AST_NO_WRITE_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> !cmdValid); // R10

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !cmdValid); // R8

  AST_BUSY_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(readMode)); // R8

  AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $countones(cmdOp) == 1); // R10

  AST_OP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> cmdOp == 7'd0); // R10

  AST_SECTOR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp[1]) |-> cmdAddr[SECTOR_LSB-1:0] == '0); // R3

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    readMode != 2'd3); // R4

endmodule

bind unlock_cmd_decoder unlock_cmd_decoder_chk #(
  .ADDR_W     (ADDR_W),
  .SECTOR_LSB (SECTOR_LSB)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrValid  (wrValid),
  .busy     (busy),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdAddr  (cmdAddr),
  .readMode (readMode)
);

// File: tb/unlock_cmd_decoder_tb.sv
module unlock_cmd_decoder_tb;

  localparam int AW = 19;
  localparam int DW = 16;

  typedef struct packed {
    logic [3:0]    req;
    logic          bsy;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          expValid;
    logic [6:0]    expOp;
    logic [AW-1:0] expAddr;
    logic [1:0]    expMode;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VEC [NV] = '{
    // R2 program
    '{4'd2,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd2,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd2,1'b0,19'h05555,16'h00A0,1'b0,7'h00,19'h0,2'd0},
    '{4'd2,1'b0,19'h7ABCD,16'h1234,1'b1,7'h01,19'h7ABCD,2'd0},
    // R3 chip erase
    '{4'd3,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h05555,16'h0080,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h05555,16'h0010,1'b1,7'h08,19'h0,2'd0},
    // R3 sector erase, R7 upper bits set
    '{4'd7,1'b0,19'h7D555,16'hFFAA,1'b0,7'h00,19'h0,2'd0},
    '{4'd7,1'b0,19'h3AAAA,16'h0155,1'b0,7'h00,19'h0,2'd0},
    '{4'd7,1'b0,19'h05555,16'hAB80,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h6C9FF,16'h0030,1'b1,7'h02,19'h6C800,2'd0},
    // R3 block erase
    '{4'd3,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h05555,16'h0080,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd3,1'b0,19'h5B123,16'h0050,1'b1,7'h04,19'h58000,2'd0},
    // R4 ID entry
    '{4'd4,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd4,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd4,1'b0,19'h05555,16'h0090,1'b1,7'h10,19'h0,2'd1},
    // R5 single exit at arbitrary address, single query entry
    '{4'd5,1'b0,19'h12345,16'h00F0,1'b1,7'h40,19'h0,2'd0},
    '{4'd5,1'b0,19'h00055,16'h0098,1'b1,7'h20,19'h0,2'd2},
    // R4 three-cycle exit from query mode
    '{4'd4,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd2},
    '{4'd4,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd2},
    '{4'd4,1'b0,19'h05555,16'h00F0,1'b1,7'h40,19'h0,2'd0},
    // R4 three-cycle query entry
    '{4'd4,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd4,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd4,1'b0,19'h05555,16'h0098,1'b1,7'h20,19'h0,2'd2},
    // R6 abort in second cycle drops to array mode, then no resume
    '{4'd6,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd2},
    '{4'd6,1'b0,19'h02AAA,16'h0056,1'b0,7'h00,19'h0,2'd0},
    '{4'd6,1'b0,19'h05555,16'h00A0,1'b0,7'h00,19'h0,2'd0},
    // R6 abort in fourth erase cycle
    '{4'd6,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd6,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd6,1'b0,19'h05555,16'h0080,1'b0,7'h00,19'h0,2'd0},
    '{4'd6,1'b0,19'h05554,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    // R8 busy holds mode and pattern position
    '{4'd8,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd0},
    '{4'd8,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd0},
    '{4'd8,1'b0,19'h05555,16'h0090,1'b1,7'h10,19'h0,2'd1},
    '{4'd8,1'b0,19'h05555,16'h00AA,1'b0,7'h00,19'h0,2'd1},
    '{4'd8,1'b1,19'h00000,16'h00F0,1'b0,7'h00,19'h0,2'd1},
    '{4'd8,1'b1,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd1},
    '{4'd8,1'b0,19'h02AAA,16'h0055,1'b0,7'h00,19'h0,2'd1},
    '{4'd8,1'b0,19'h05555,16'h0090,1'b1,7'h10,19'h0,2'd1},
    '{4'd5,1'b0,19'h00000,16'h00F0,1'b1,7'h40,19'h0,2'd0},
    // R7 upper bits on single-cycle commands
    '{4'd7,1'b0,19'h48055,16'h7798,1'b1,7'h20,19'h0,2'd2},
    '{4'd7,1'b0,19'h7FFFF,16'h12F0,1'b1,7'h40,19'h0,2'd0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic          busy = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic          cmdValid;
  logic [6:0]    cmdOp;
  logic [AW-1:0] cmdAddr;
  logic [DW-1:0] cmdData;
  logic [1:0]    readMode;
  logic [DW-1:0] idWord;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  unlock_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .busy(busy), .rdAddr(rdAddr), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .readMode(readMode), .idWord(idWord)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one write strobe; returns at the next falling edge, where outputs show its effect
  task automatic hostWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic b);
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = a;
    wrData  = d;
    busy    = b;
    @(negedge clk);
    wrValid = 1'b0;
    busy    = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 readMode", 32'(readMode), 32'd0);
    check("R1 cmdValid", 32'(cmdValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 cmdValid idle", 32'(cmdValid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      hostWrite(VEC[i].addr, VEC[i].data, VEC[i].bsy);
      check($sformatf("R%0d vec%0d valid", VEC[i].req, i), 32'(cmdValid), 32'(VEC[i].expValid));
      check($sformatf("R%0d vec%0d op", VEC[i].req, i), 32'(cmdOp), 32'(VEC[i].expOp));
      check($sformatf("R%0d vec%0d mode", VEC[i].req, i), 32'(readMode), 32'(VEC[i].expMode));
      if (VEC[i].expValid)
        check($sformatf("R%0d vec%0d addr", VEC[i].req, i), 32'(cmdAddr), 32'(VEC[i].expAddr));
    end

    // R2 full program data, R10 pulse lasts one cycle
    hostWrite(19'h05555, 16'h00AA, 1'b0);
    hostWrite(19'h02AAA, 16'h0055, 1'b0);
    hostWrite(19'h05555, 16'h00A0, 1'b0);
    hostWrite(19'h00003, 16'hBEEF, 1'b0);
    check("R2 cmdData", 32'(cmdData), 32'hBEEF);
    check("R2 cmdAddr", 32'(cmdAddr), 32'h3);
    @(negedge clk);
    check("R10 pulse ends", 32'(cmdValid), 32'd0);
    check("R10 op cleared", 32'(cmdOp), 32'd0);

    // R9 identification words
    hostWrite(19'h05555, 16'h00AA, 1'b0);
    hostWrite(19'h02AAA, 16'h0055, 1'b0);
    hostWrite(19'h05555, 16'h0090, 1'b0);
    check("R9 mode ident", 32'(readMode), 32'd1);
    rdAddr = 19'd0; #1;
    check("R9 manufacturer", 32'(idWord), 32'h00BF);
    rdAddr = 19'd1; #1;
    check("R9 device", 32'(idWord), 32'h273E);
    rdAddr = 19'd2; #1;
    check("R9 other address", 32'(idWord), 32'h0);
    hostWrite(19'h00000, 16'h00F0, 1'b0);
    rdAddr = 19'd0; #1;
    check("R9 array mode", 32'(idWord), 32'h0);

    // R1 reset in the middle of a pattern
    hostWrite(19'h05555, 16'h00AA, 1'b0);
    hostWrite(19'h02AAA, 16'h0055, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid reset mode", 32'(readMode), 32'd0);
    check("R1 mid reset valid", 32'(cmdValid), 32'd0);
    rstN = 1'b1;
    hostWrite(19'h05555, 16'h00A0, 1'b0);
    check("R1 no resume after reset", 32'(cmdValid), 32'd0);
    hostWrite(19'h00010, 16'h1111, 1'b0);
    check("R1 no program after reset", 32'(cmdValid), 32'd0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule